// File: doc/BRIEF.md
# Host Bus Capture Buffer Target

This block sits between a host processor's 16-bit parallel bus and an on-chip sample buffer. The host starts every access and the block only answers. A read or write is signalled by an asynchronous strobe. Each strobe passes through a two-flop synchroniser, and a rising edge of the synchronised strobe marks one access. The address and write data are latched in the cycle of that edge. Reads then stretch the host cycle with a wait-state output, which covers address registration and the block-RAM output register. The word is presented when the wait state is released.

The buffer holds 8-bit sensor samples. Each host word carries two adjacent samples. The buffer is kept as two banks. The sensor side writes into the back bank while a capture is running. When the sensor reports completion, the banks swap, so the host always reads the last finished capture. A second address region holds a control word and a status word. Writing the control word issues a one-cycle start pulse to the sensor side. The status word reports whether a capture is running and whether one has finished.

Top module: `hbus_capture_target`

## Requirements
- R1: After reset, host_wait, host_rdata and cap_start are all 0, and the status word reads 0.
- R2: A rising read strobe makes host_wait rise after the third rising clock edge counted from strobe assertion. It then stays high for exactly two clock cycles.
- R3: host_rdata takes the read result on the edge where host_wait falls. It keeps that value until the next read completes.
- R4: Addresses with bit 9 clear select buffer word w. That word returns sample 2w in bits 7:0 and sample 2w+1 in bits 15:8.
- R5: A host write to address 0x200 with data bit 0 set drives cap_start high for exactly one cycle, after the fourth rising edge from strobe assertion. The same write with bit 0 clear gives no pulse.
- R6: The status word sits at address 0x201, with bit 0 = busy and bit 1 = done. A start sets busy and clears done. Sensor completion clears busy and sets done. done then stays set until the next start.
- R7: Host writes to the buffer region leave its contents unchanged.
- R8: Sensor samples written during a capture are not visible to host reads until sensor completion is signalled. After completion they are visible.
- R9: A sensor completion pulse while no capture is running changes neither the status word nor the data the host reads.
- R10: A strobe held high for many cycles produces exactly one access, so host_wait is high for only two cycles in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Asynchronous read strobe, active high |
| host_wr | input | 1 | Asynchronous write strobe, active high |
| host_addr | input | 10 | Word address; bit 9 selects the register region |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid when host_wait falls |
| host_wait | output | 1 | Wait state stretching a read |
| cap_start | output | 1 | One-cycle capture start to the sensor side |
| snsr_we | input | 1 | Sensor sample write enable |
| snsr_addr | input | 10 | Sample index within the capture |
| snsr_data | input | 8 | Sample value |
| snsr_done | input | 1 | Capture complete pulse |

## Verification
A read-phase counter that is stuck or skips a state shows at the ports in the same access. host_wait then stays high for too long or too short, or the word appears on an edge other than the release. A bank-select bit that is wrong shows on the first read after a completion: the host sees fresh or stale samples where the other was expected. A busy/done flag that is wrong shows on the next status read.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_ADDR = 2'd1,
    RD_DATA = 2'd2
  } rd_phase_e;

  localparam int unsigned HOST_DW = 16;
  localparam int unsigned SMP_DW  = 8;
  localparam int unsigned LANES   = HOST_DW / SMP_DW;
endpackage

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] strobe_in,
  output logic [N-1:0] rise_evt
);
  logic [N-1:0] meta_q, sync_q, last_q;

  for (genvar i = 0; i < N; i++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        last_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= strobe_in[i];
        sync_q[i] <= meta_q[i];
        last_q[i] <= sync_q[i];
      end
    end
    assign rise_evt[i] = sync_q[i] & ~last_q[i];
  end
endmodule

// File: rtl/hbus_byte_ram.sv
module hbus_byte_ram #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hbus_capture_ctl.sv
module hbus_capture_ctl (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic snsr_done,
  output logic cap_start,
  output logic busy,
  output logic done,
  output logic front_bank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_start  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      front_bank <= 1'b0;
    end else begin
      cap_start <= start_req;
      if (start_req) begin
        busy <= 1'b1;
        done <= 1'b0;
      end else if (snsr_done && busy) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        front_bank <= ~front_bank;
      end
    end
  end
endmodule

// File: rtl/hbus_capture_target.sv
module hbus_capture_target
  import hbus_pkg::*;
#(
  parameter int unsigned SAMPLES = 1024,
  localparam int unsigned SA_W   = $clog2(SAMPLES),
  localparam int unsigned WA_W   = SA_W - 1,
  localparam int unsigned HA_W   = WA_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [HA_W-1:0]    host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  output logic               host_wait,
  output logic               cap_start,
  input  logic               snsr_we,
  input  logic [SA_W-1:0]    snsr_addr,
  input  logic [SMP_DW-1:0]  snsr_data,
  input  logic               snsr_done
);
  localparam int unsigned BANK_DEPTH = 2 * (SAMPLES / LANES);
  localparam logic [WA_W-1:0] OFS_CTRL = '0;
  localparam logic [WA_W-1:0] OFS_STAT = WA_W'(1);

  logic [1:0] evt;
  logic       rd_evt, wr_evt;

  hbus_strobe_sync #(.N(2)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .strobe_in({host_wr, host_rd}),
    .rise_evt (evt)
  );
  assign rd_evt = evt[0];
  assign wr_evt = evt[1];

  // write path: latch, then commit one cycle later
  logic              wr_pend;
  logic [HA_W-1:0]   w_addr;
  logic [HOST_DW-1:0] w_data;
  logic              start_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_pend <= 1'b0;
      w_addr  <= '0;
      w_data  <= '0;
    end else begin
      wr_pend <= wr_evt;
      if (wr_evt) begin
        w_addr <= host_addr;
        w_data <= host_wdata;
      end
    end
  end

  // buffer-region writes are dropped here by decode
  assign start_req = wr_pend && w_addr[HA_W-1] &&
                     (w_addr[WA_W-1:0] == OFS_CTRL) && w_data[0];

  logic busy_q, done_q, front_bank;

  hbus_capture_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .snsr_done (snsr_done),
    .cap_start (cap_start),
    .busy      (busy_q),
    .done      (done_q),
    .front_bank(front_bank)
  );

  // sample storage: one byte RAM per lane, bank bit on top of index
  logic [HA_W-1:0] a_q;
  logic [SMP_DW-1:0] lane_q [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_we;
    assign lane_we = snsr_we && (snsr_addr[0] == l[0]);
    hbus_byte_ram #(.DEPTH(BANK_DEPTH)) u_ram (
      .clk  (clk),
      .we   (lane_we),
      .waddr({~front_bank, snsr_addr[SA_W-1:1]}),
      .wdata(snsr_data),
      .raddr({front_bank, a_q[WA_W-1:0]}),
      .rdata(lane_q[l])
    );
  end

  // read path: latch address, one RAM cycle, then present
  rd_phase_e ph;
  logic [HOST_DW-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (a_q[HA_W-1]) begin
      if (a_q[WA_W-1:0] == OFS_STAT) rd_word = {{(HOST_DW-2){1'b0}}, done_q, busy_q};
    end else begin
      for (int l = 0; l < LANES; l++) rd_word[l*SMP_DW +: SMP_DW] = lane_q[l];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= RD_IDLE;
      a_q        <= '0;
      host_wait  <= 1'b0;
      host_rdata <= '0;
    end else begin
      unique case (ph)
        RD_IDLE: if (rd_evt) begin
          a_q       <= host_addr;
          host_wait <= 1'b1;
          ph        <= RD_ADDR;
        end
        RD_ADDR: ph <= RD_DATA;
        RD_DATA: begin
          host_rdata <= rd_word;
          host_wait  <= 1'b0;
          ph         <= RD_IDLE;
        end
        default: ph <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hbus_capture_target_chk.sv
module hbus_capture_target_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_wait,
  input logic [15:0] host_rdata,
  input logic        cap_start,
  input logic        busy,
  input logic        done,
  input logic        rd_evt
);
  AST_WAIT_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(host_wait) |=> host_wait); // R2
  AST_WAIT_MAX: assert property (@(posedge clk) disable iff (rst)
    (host_wait && $past(host_wait)) |=> !host_wait); // R2
  AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(host_wait) |-> $past(rd_evt)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$fell(host_wait) |-> $stable(host_rdata)); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    cap_start |=> !cap_start); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R6
endmodule

bind hbus_capture_target hbus_capture_target_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_wait (host_wait),
  .host_rdata(host_rdata),
  .cap_start (cap_start),
  .busy      (busy_q),
  .done      (done_q),
  .rd_evt    (rd_evt)
);

// File: tb/hbus_capture_target_tb.sv
module hbus_capture_target_tb;
  localparam logic [9:0] A_CTRL = 10'h200;
  localparam logic [9:0] A_STAT = 10'h201;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [9:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic host_wait, cap_start;
  logic snsr_we = 1'b0, snsr_done = 1'b0;
  logic [9:0] snsr_addr = '0;
  logic [7:0] snsr_data = '0;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  hbus_capture_target u_dut (
    .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .cap_start(cap_start), .snsr_we(snsr_we),
    .snsr_addr(snsr_addr), .snsr_data(snsr_data), .snsr_done(snsr_done)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_read(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R2 wait after edge3", 16'(host_wait), 16'd1);
    @(negedge clk); check("R2 wait after edge4", 16'(host_wait), 16'd1);
    @(negedge clk); check("R2 wait low after edge5", 16'(host_wait), 16'd0);
    d = host_rdata;
    host_rd = 1'b0;
    idle(3);
  endtask

  task automatic host_write(input logic [9:0] a, input logic [15:0] d, input logic pulse_exp);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R5 no early start", 16'(cap_start), 16'd0);
    @(negedge clk); check("R5 start pulse", 16'(cap_start), 16'(pulse_exp));
    @(negedge clk); check("R5 start one cycle", 16'(cap_start), 16'd0);
    host_wr = 1'b0;
    idle(3);
  endtask

  task automatic snsr_put(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    snsr_we = 1'b1; snsr_addr = a; snsr_data = d;
    @(negedge clk);
    snsr_we = 1'b0;
  endtask

  task automatic snsr_finish();
    @(negedge clk); snsr_done = 1'b1;
    @(negedge clk); snsr_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 wait", 16'(host_wait), 16'd0);
    check("R1 rdata", host_rdata, 16'd0);
    check("R1 cap_start", 16'(cap_start), 16'd0);
    host_read(A_STAT, d);
    check("R1 status", d, 16'd0);
  endtask

  task automatic t_first_capture();
    logic [15:0] d;
    host_write(A_CTRL, 16'h0000, 1'b0);
    host_read(A_STAT, d); check("R5 no start keeps idle", d, 16'd0);
    host_write(A_CTRL, 16'h0001, 1'b1);
    host_read(A_STAT, d); check("R6 busy after start", d, 16'h0001);
    for (int i = 0; i < 8; i++) snsr_put(10'(i), 8'(8'h10 + i));
    snsr_finish();
    host_read(A_STAT, d); check("R6 done after finish", d, 16'h0002);
    for (int w = 0; w < 4; w++) begin
      host_read(10'(w), d);
      check("R4 packing", d, {8'(8'h11 + 2*w), 8'(8'h10 + 2*w)});
    end
    idle(4);
    check("R3 rdata held", host_rdata, 16'h1716);
  endtask

  task automatic t_ignored();
    logic [15:0] d;
    host_write(10'h000, 16'hFFFF, 1'b0);
    host_read(10'h000, d); check("R7 buffer write ignored", d, 16'h1110);
    snsr_finish();
    host_read(A_STAT, d); check("R9 status unchanged", d, 16'h0002);
    host_read(10'h001, d); check("R9 data unchanged", d, 16'h1312);
  endtask

  task automatic t_second_capture();
    logic [15:0] d;
    host_write(A_CTRL, 16'h0001, 1'b1);
    host_read(A_STAT, d); check("R6 start clears done", d, 16'h0001);
    snsr_put(10'd0, 8'hA0);
    snsr_put(10'd1, 8'hA1);
    host_read(10'h000, d); check("R8 old capture visible", d, 16'h1110);
    snsr_finish();
    host_read(10'h000, d); check("R8 new capture visible", d, 16'hA1A0);
    host_read(A_STAT, d); check("R6 done again", d, 16'h0002);
  endtask

  task automatic t_held_strobe();
    int hi = 0;
    @(negedge clk);
    host_addr = A_STAT; host_rd = 1'b1;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if (host_wait) hi++;
    end
    check("R10 held strobe single access", 16'(hi), 16'd2);
    check("R10 data", host_rdata, 16'h0002);
    host_rd = 1'b0;
    idle(3);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_first_capture();
    t_ignored();
    t_second_capture();
    t_held_strobe();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule